// File: doc/BRIEF.md
# DMA Channel Interrupt and Accounting Registers

This block is the interrupt side of a single DMA channel. The channel sends one-cycle event strobes, for example completion, pause or bus errors. The block latches each strobe into a sticky 12-bit status register. A per-source mask decides which status bits reach one level-sensitive interrupt line.

Software reaches the block over a small register port. It reads the status and clears bits by writing ones to them. It can read the mask, but changes it only through two command registers: one unmasks the sources whose bits are written as one, the other masks them.

Descriptor-completion strobes are also counted. The block keeps one 8-bit counter for source descriptors and one for destination descriptors. A read returns the count and clears the counter. If a counter wraps, the block raises an overflow status bit. An access to an offset that holds no register raises its own status bit.

Top module: `dma_irq_unit`

## Requirements
- R1: After reset the status register reads 0, the mask reads 0xFFF, both counters read 0 and `irqOut` is low.
- R2: A one on `evtIn` bit k sets status bit k, for k in 11..6, 3, 2 and 1 (11 pause, 10 done, 9 write-data error, 8 read-data error, 7 destination-descriptor fetch error, 6 source-descriptor fetch error, 3 byte-count overflow, 2 destination descriptor done, 1 source descriptor done). Strobes on `evtIn` bits 5, 4 and 0 have no effect.
- R3: A write to the status register at offset 0x00 clears every bit written as one. Read data bits 31..12 are always zero.
- R4: A write to the mask register at offset 0x04 has no effect. A write to offset 0x08 clears each mask bit written as one. A write to offset 0x0C sets each mask bit written as one. Offsets 0x08 and 0x0C read as zero.
- R5: `irqOut` is high exactly when some status bit is set while its mask bit is clear. It reflects a change of status or mask one clock after that change.
- R6: A strobe on `evtIn` bit 1 adds one to the source counter at offset 0x10. A strobe on bit 2 adds one to the destination counter at offset 0x14.
- R7: When an increment takes a counter from 255 to 0, status bit 4 is set for the source counter, or status bit 5 for the destination counter.
- R8: Reading a counter returns its value and clears it. Writes to a counter have no effect. If an increment arrives in the same cycle as the clearing read, the read returns the old value and the counter becomes 1.
- R9: An access to any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10 or 0x14 sets status bit 0. Such a read returns 0 and such a write changes nothing else.
- R10: If a write-one-to-clear and an event strobe hit the same status bit in the same cycle, the bit ends up set.
- R11: The block accepts a request when `regValid` is high and `regReady` is low. It raises `regReady` for exactly one cycle in the next cycle, with the read data on `regRdata`. The register effect of the request is visible from that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register request valid, held until `regReady` |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W | Byte offset of the register |
| regWdata | input | DATA_W | Write data |
| regReady | output | 1 | One-cycle response pulse |
| regRdata | output | DATA_W | Read data, valid with `regReady` |
| evtIn | input | 12 | Single-cycle event strobes from the channel |
| irqOut | output | 1 | Registered level interrupt |

## Verification
A status bit that is stuck, lost or cleared by the wrong write shows up on `irqOut` two clocks after the event, once its source is unmasked. A plain read of the status register shows it in the response cycle. A wrong mask update shows on the next mask read, and on `irqOut` one cycle after the command. An accounting counter that is off by one stays hidden until its next read or its wrap. Long runs of completion strobes followed by a read therefore check both the count and the overflow flag, as well as the read-clear race.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int NUM_EV = 12;

  // status bit positions the block itself drives
  localparam int B_INVALID  = 0;
  localparam int B_SRC_DONE = 1;
  localparam int B_DST_DONE = 2;
  localparam int B_SRC_OVF  = 4;
  localparam int B_DST_OVF  = 5;

  // strobes accepted from the channel; internal-only bits are cut off
  localparam logic [NUM_EV-1:0] EXT_EV_MASK =
    ~(NUM_EV'(1) << B_INVALID | NUM_EV'(1) << B_SRC_OVF | NUM_EV'(1) << B_DST_OVF);

  // register byte offsets
  localparam int OFF_STATUS = 'h00;
  localparam int OFF_MASK   = 'h04;
  localparam int OFF_UNMASK = 'h08;
  localparam int OFF_DOMASK = 'h0C;
  localparam int OFF_SACCT  = 'h10;
  localparam int OFF_DACCT  = 'h14;

  typedef enum logic [2:0] {
    T_STATUS, T_MASK, T_UNMASK, T_DOMASK, T_SACCT, T_DACCT, T_NONE
  } regTarget_t;

  typedef struct packed {
    logic [NUM_EV-1:0] stsClr;
    logic [NUM_EV-1:0] maskClr;
    logic [NUM_EV-1:0] maskSet;
    logic              badAccess;
    logic              srcAcctRd;
    logic              dstAcctRd;
  } ctrlStrb_t;
endpackage

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl
  import dmairq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                regValid,
  input  logic                regWrite,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  output logic                regReady,
  output logic [DATA_W-1:0]   regRdata,
  input  logic [NUM_EV-1:0]   status,
  input  logic [NUM_EV-1:0]   mask,
  input  logic [2*CNT_W-1:0]  acctFlat,
  output ctrlStrb_t           strb
);
  logic              accept;
  regTarget_t        target;
  logic [NUM_EV-1:0] wBits;
  logic [DATA_W-1:0] rdNext;
  logic              unusedHi;

  assign accept   = regValid & ~regReady;
  assign wBits    = regWdata[NUM_EV-1:0];
  assign unusedHi = ^regWdata[DATA_W-1:NUM_EV];

  always_comb begin
    if      (regAddr == ADDR_W'(OFF_STATUS)) target = T_STATUS;
    else if (regAddr == ADDR_W'(OFF_MASK))   target = T_MASK;
    else if (regAddr == ADDR_W'(OFF_UNMASK)) target = T_UNMASK;
    else if (regAddr == ADDR_W'(OFF_DOMASK)) target = T_DOMASK;
    else if (regAddr == ADDR_W'(OFF_SACCT))  target = T_SACCT;
    else if (regAddr == ADDR_W'(OFF_DACCT))  target = T_DACCT;
    else                                     target = T_NONE;
  end

  always_comb begin
    strb           = '0;
    strb.badAccess = accept && (target == T_NONE);
    if (accept && regWrite) begin
      if (target == T_STATUS) strb.stsClr  = wBits;
      if (target == T_UNMASK) strb.maskClr = wBits;
      if (target == T_DOMASK) strb.maskSet = wBits;
    end
    if (accept && !regWrite) begin
      strb.srcAcctRd = (target == T_SACCT);
      strb.dstAcctRd = (target == T_DACCT);
    end
  end

  always_comb begin
    rdNext = '0;
    if (!regWrite) begin
      case (target)
        T_STATUS: rdNext = DATA_W'(status);
        T_MASK:   rdNext = DATA_W'(mask);
        T_SACCT:  rdNext = DATA_W'(acctFlat[CNT_W-1:0]);
        T_DACCT:  rdNext = DATA_W'(acctFlat[2*CNT_W-1:CNT_W]);
        default:  rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regReady <= 1'b0;
      regRdata <= '0;
    end else begin
      regReady <= accept;
      if (accept) regRdata <= rdNext;
    end
  end
endmodule

// File: rtl/dmairq_dpath.sv
module dmairq_dpath
  import dmairq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrb_t          strb,
  input  logic [NUM_EV-1:0]  evtIn,
  output logic [NUM_EV-1:0]  status,
  output logic [NUM_EV-1:0]  mask,
  output logic [2*CNT_W-1:0] acctFlat,
  output logic               irqOut
);
  localparam int N_ACCT = 2;

  logic [N_ACCT-1:0] acctInc, acctRd, acctOvf;
  logic [NUM_EV-1:0] setVec;

  assign acctInc = {evtIn[B_DST_DONE], evtIn[B_SRC_DONE]};
  assign acctRd  = {strb.dstAcctRd, strb.srcAcctRd};

  for (genvar g = 0; g < N_ACCT; g++) begin : g_acct
    logic [CNT_W-1:0] cntQ;
    always_ff @(posedge clk) begin
      if (!rst_n)          cntQ <= '0;
      else if (acctRd[g])  cntQ <= CNT_W'(acctInc[g]);
      else if (acctInc[g]) cntQ <= cntQ + 1'b1;
    end
    assign acctOvf[g] = acctInc[g] & ~acctRd[g] & (&cntQ);
    assign acctFlat[g*CNT_W +: CNT_W] = cntQ;
  end

  always_comb begin
    setVec             = evtIn & EXT_EV_MASK;
    setVec[B_SRC_OVF]  = acctOvf[0];
    setVec[B_DST_OVF]  = acctOvf[1];
    setVec[B_INVALID]  = strb.badAccess;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '1;
      irqOut <= 1'b0;
    end else begin
      status <= (status & ~strb.stsClr) | setVec;
      mask   <= (mask & ~strb.maskClr) | strb.maskSet;
      irqOut <= |(status & ~mask);
    end
  end
endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
  import dmairq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic              regReady,
  output logic [DATA_W-1:0] regRdata,
  input  logic [NUM_EV-1:0] evtIn,
  output logic              irqOut
);
  ctrlStrb_t          strb;
  logic [NUM_EV-1:0]  status;
  logic [NUM_EV-1:0]  mask;
  logic [2*CNT_W-1:0] acctFlat;

  dmairq_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regReady(regReady), .regRdata(regRdata),
    .status(status), .mask(mask), .acctFlat(acctFlat), .strb(strb)
  );

  dmairq_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .evtIn(evtIn),
    .status(status), .mask(mask), .acctFlat(acctFlat), .irqOut(irqOut)
  );
endmodule

// File: rtl/dmairq_chk.sv
module dmairq_chk
  import dmairq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               regValid,
  input logic               regWrite,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DATA_W-1:0]  regWdata,
  input logic               regReady,
  input logic [DATA_W-1:0]  regRdata,
  input logic [NUM_EV-1:0]  evtIn,
  input logic               irqOut,
  input logic [NUM_EV-1:0]  status,
  input logic [NUM_EV-1:0]  mask,
  input logic [2*CNT_W-1:0] acctFlat
);
  logic take, mapped, maskCmd;
  assign take    = regValid && !regReady;
  assign mapped  = regAddr == ADDR_W'(OFF_STATUS) || regAddr == ADDR_W'(OFF_MASK) ||
                   regAddr == ADDR_W'(OFF_UNMASK) || regAddr == ADDR_W'(OFF_DOMASK) ||
                   regAddr == ADDR_W'(OFF_SACCT)  || regAddr == ADDR_W'(OFF_DACCT);
  assign maskCmd = take && regWrite &&
                   (regAddr == ADDR_W'(OFF_UNMASK) || regAddr == ADDR_W'(OFF_DOMASK));

  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(evtIn & EXT_EV_MASK)) == $past(evtIn & EXT_EV_MASK)));

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    regReady |-> (regRdata[DATA_W-1:NUM_EV] == '0));

  p_unmask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && regWrite && regAddr == ADDR_W'(OFF_UNMASK)) |=>
      (mask == ($past(mask) & ~$past(regWdata[NUM_EV-1:0]))));

  p_domask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && regWrite && regAddr == ADDR_W'(OFF_DOMASK)) |=>
      (mask == ($past(mask) | $past(regWdata[NUM_EV-1:0]))));

  p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !maskCmd |=> $stable(mask));

  p_irq_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irqOut == |($past(status) & ~$past(mask))));

  p_src_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evtIn[B_SRC_DONE] && (&acctFlat[CNT_W-1:0]) &&
     !(take && !regWrite && regAddr == ADDR_W'(OFF_SACCT))) |=> status[B_SRC_OVF]);

  p_bad_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !mapped) |=> (status[B_INVALID] && regRdata == '0));

  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    regReady |=> !regReady);

  p_ready_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> regReady);
endmodule

bind dma_irq_unit dmairq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .regValid(regValid), .regWrite(regWrite),
  .regAddr(regAddr), .regWdata(regWdata), .regReady(regReady), .regRdata(regRdata),
  .evtIn(evtIn), .irqOut(irqOut), .status(status), .mask(mask), .acctFlat(acctFlat)
);

// File: tb/test_dma_irq_unit.sv
module test_dma_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regValid = 1'b0, regWrite = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        regReady;
  logic [31:0] regRdata;
  logic [11:0] evtIn = '0;
  logic        irqOut;

  int nChk = 0, nFail = 0;
  bit finished = 0;

  logic [11:0] mSts = '0, mMsk = 12'hFFF;
  logic [7:0]  mSrc = '0, mDst = '0;

  always #5 clk = ~clk;

  dma_irq_unit i_dma_irq_unit (
    .clk(clk), .rst_n(rst_n), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regReady(regReady),
    .regRdata(regRdata), .evtIn(evtIn), .irqOut(irqOut)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit isMapped(logic [7:0] a);
    return a == 8'h00 || a == 8'h04 || a == 8'h08 || a == 8'h0C || a == 8'h10 || a == 8'h14;
  endfunction

  function automatic logic [31:0] readModel(logic [7:0] a);
    case (a)
      8'h00:   return {20'b0, mSts};
      8'h04:   return {20'b0, mMsk};
      8'h10:   return {24'b0, mSrc};
      8'h14:   return {24'b0, mDst};
      default: return 32'b0;
    endcase
  endfunction

  // one request and/or event strobe, with model update and checks
  task automatic doOp(bit acc, bit wr, logic [7:0] addr, logic [31:0] wd,
                      logic [11:0] evt, string tag);
    logic        irqBefore = |(mSts & ~mMsk);
    logic [31:0] expRd = readModel(addr);
    bit clrS = acc && !wr && addr == 8'h10;
    bit clrD = acc && !wr && addr == 8'h14;
    bit ovfS = evt[1] && !clrS && mSrc == 8'hFF;
    bit ovfD = evt[2] && !clrD && mDst == 8'hFF;
    logic [11:0] w1c = (acc && wr && addr == 8'h00) ? wd[11:0] : 12'h0;
    @(negedge clk);
    regValid = acc; regWrite = wr; regAddr = addr; regWdata = wd; evtIn = evt;
    @(negedge clk);
    regValid = 1'b0; evtIn = '0;
    if (acc) begin
      chk({tag, " R11 ready"}, {31'b0, regReady}, 32'd1);
      if (!wr) chk({tag, " rdata"}, regRdata, expRd);
    end
    chk({tag, " R5 irq lag"}, {31'b0, irqOut}, {31'b0, irqBefore});
    mSrc = clrS ? {7'b0, evt[1]} : mSrc + {7'b0, evt[1]};
    mDst = clrD ? {7'b0, evt[2]} : mDst + {7'b0, evt[2]};
    mSts = (mSts & ~w1c) | (evt & 12'hFCE) | (12'(ovfS) << 4) | (12'(ovfD) << 5)
           | 12'(acc && !isMapped(addr));
    if (acc && wr && addr == 8'h08) mMsk = mMsk & ~wd[11:0];
    if (acc && wr && addr == 8'h0C) mMsk = mMsk | wd[11:0];
    @(negedge clk);
    chk({tag, " R5 irq"}, {31'b0, irqOut}, {31'b0, |(mSts & ~mMsk)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 irq after reset", {31'b0, irqOut}, 32'd0);
    doOp(1, 0, 8'h00, 0, 0, "R1 status");
    doOp(1, 0, 8'h04, 0, 0, "R1 mask");
    doOp(1, 0, 8'h10, 0, 0, "R1 src count");
    doOp(1, 0, 8'h14, 0, 0, "R1 dst count");

    // mask access
    doOp(1, 1, 8'h04, 32'h0, 0, "R4 direct write");
    doOp(1, 0, 8'h04, 0, 0, "R4 mask kept");
    doOp(1, 1, 8'h08, 32'hFFFF_F400, 0, "R4 unmask");
    doOp(1, 0, 8'h04, 0, 0, "R4 mask after unmask");
    doOp(1, 0, 8'h08, 0, 0, "R4 unmask reads zero");
    doOp(1, 0, 8'h0C, 0, 0, "R4 domask reads zero");

    // events, irq, w1c
    doOp(0, 0, 0, 0, 12'h400, "R2 done event");
    doOp(1, 0, 8'h00, 0, 0, "R2 R5 status shows done");
    doOp(0, 0, 0, 0, 12'h031, "R2 internal bits ignored");
    doOp(1, 0, 8'h00, 0, 0, "R2 status unchanged");
    doOp(1, 1, 8'h00, 32'hFFFF_F400, 0, "R3 w1c");
    doOp(1, 0, 8'h00, 0, 0, "R3 status cleared");
    doOp(1, 1, 8'h00, 32'h400, 12'h400, "R10 event beats clear");
    doOp(1, 0, 8'h00, 0, 0, "R10 bit kept");
    doOp(1, 1, 8'h0C, 32'h400, 0, "R4 R5 remask");

    // accounting
    for (int i = 0; i < 3; i++) doOp(0, 0, 0, 0, 12'h002, "R6 src done");
    doOp(1, 1, 8'h10, 32'h55, 0, "R8 counter write ignored");
    doOp(1, 0, 8'h10, 0, 0, "R6 src count three");
    doOp(1, 0, 8'h10, 0, 0, "R8 cleared by read");
    doOp(0, 0, 0, 0, 12'h002, "R8 prep");
    doOp(1, 0, 8'h10, 0, 12'h002, "R8 read with event");
    doOp(1, 0, 8'h10, 0, 0, "R8 counts one");
    for (int i = 0; i < 256; i++) doOp(0, 0, 0, 0, 12'h004, "R7 dst done");
    doOp(1, 0, 8'h14, 0, 0, "R7 dst wrapped");
    doOp(1, 0, 8'h00, 0, 0, "R7 overflow flag");

    // invalid accesses
    doOp(1, 1, 8'h00, 32'hFFF, 0, "R9 prep clear");
    doOp(1, 0, 8'h40, 0, 0, "R9 bad read");
    doOp(1, 1, 8'h44, 32'hFFF, 0, "R9 bad write");
    doOp(1, 0, 8'h00, 0, 0, "R9 flag set");
    doOp(1, 0, 8'h04, 0, 0, "R9 mask untouched");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [7:0]  a;
      logic [11:0] e;
      logic [31:0] d;
      case ($urandom % 9)
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
        4: a = 8'h10; 5: a = 8'h14; 6: a = 8'h18; 7: a = 8'h3C;
        default: a = 8'h02;
      endcase
      e = ($urandom % 3 == 0) ? 12'(1 << ($urandom % 12)) : 12'h0;
      d = ($urandom % 4 == 0) ? $urandom : ($urandom & 32'hFFF);
      doOp(($urandom % 4) != 0, $urandom % 2, a, d, e, "random R2 R3 R4 R6 R8 R9");
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule